// File: doc/BRIEF.md
# Two-Stage Fetch and Program-Counter Sequencer

This block generates the program-memory address for a small 8-bit accumulator core whose program counter is 10 bits wide. An instruction cycle is four phase ticks long (T1 to T4). While the execute stage works on one instruction, the sequencer fetches the next one. At the T4-to-T1 boundary, the fetched word moves into the instruction register and the program counter steps forward. A straight-line instruction therefore finishes in one instruction cycle.

The execute stage drives decoded strobes that the block samples at the boundary:

- an absolute jump or call to a target address;
- an interrupt vector load to a fixed vector address;
- a write of the low PC byte, which stays inside the current 256-word page;
- a taken conditional skip.

Any of these throws away the word that was already prefetched. The instruction register is loaded with a no-operation word, and a bubble flag is raised for one instruction cycle. The execute stage must not act on that slot. Program memory sits outside the block: it is a synchronous read port that returns the word at the fetch address one clock later.

Top module: `fetch_sequencer`

## Requirements
- R1: While the reset input is high at a clock edge, the block loads these values: fetch address 000h, phase T1 (code 0), instruction register equal to the no-operation word 0000h, and bubble high.
- R2: The phase output advances by one on each clock where the tick input is high, in the order T1=0, T2=1, T3=2, T4=3, and then back to T1. It holds its value on clocks where the tick input is low.
- R3: The fetch address, the instruction register and the bubble flag change only on the boundary clock, which is a clock where the tick input is high and the phase is T4. Strobes present at any other clock have no effect.
- R4: On a boundary with no strobe acted on, the instruction register takes the memory read data, bubble goes low, and the fetch address increments by one.
- R5: A sequential increment wraps the fetch address from 3FFh to 000h.
- R6: A jump or call strobe sends the fetch address to the full 10-bit target. The instruction register is loaded with 0000h and bubble goes high.
- R7: An interrupt vector load sends the fetch address to the vector address parameter (default 004h). It ignores the target input, and it flushes in the same way as a jump.
- R8: A low-byte write sends the fetch address to the concatenation of the current fetch address bits [9:8] and target bits [7:0], and it flushes. Target bits [9:8] are ignored.
- R9: A taken skip increments the fetch address past the discarded word and flushes.
- R10: When several strobes arrive together, the priority is vector load first, then jump or call, then low-byte write, then skip.
- R11: Strobes are ignored on a boundary where bubble is already high. That boundary behaves as in R4.
- R12: Bubble stays high for exactly one instruction cycle after a flush. It then clears on the next boundary unless a new flush occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Phase advance enable |
| ctl_jump | input | 1 | Absolute jump strobe |
| ctl_call | input | 1 | Call strobe, redirects like a jump |
| ctl_skip | input | 1 | Conditional skip taken |
| ctl_pcl_wr | input | 1 | Write to the low program-counter byte |
| ctl_vec | input | 1 | Interrupt vector load |
| tgt_addr | input | 10 | Jump, call or low-byte target |
| mem_rdata | input | 16 | Word read from program memory |
| phase | output | 2 | Current phase, T1=0 to T4=3 |
| fetch_addr | output | 10 | Program-memory fetch address (the PC) |
| instr | output | 16 | Instruction register for the execute stage |
| bubble | output | 1 | Current slot is a discarded dummy cycle |

## Verification
The bench walks through these corner cases:

- The sequential wrap at 3FFh. A design that saturates there or widens the counter would fetch a wrong address.
- A low-byte write whose target carries foreign page bits. A design that took those bits would leave the current page.
- Every pairing of strobes. A design with the priority reordered would land on the jump target, or on the page-local address, instead of the vector.
- Strobes presented during a bubble slot. A design that honoured them would redirect a second time on a no-operation.
- Stalled ticks held across a pending jump. A design that acted before the T4 boundary would move the fetch address mid-cycle.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  typedef enum logic [1:0] {
    PH_T1 = 2'd0,
    PH_T2 = 2'd1,
    PH_T3 = 2'd2,
    PH_T4 = 2'd3
  } phase_e;

  typedef enum logic [2:0] {
    RD_SEQ,
    RD_SKIP,
    RD_PAGE,
    RD_ABS,
    RD_VEC
  } redir_e;

endpackage

// File: rtl/fs_phase_gen.sv
module fs_phase_gen
  import fseq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   tick,
  output phase_e phase,
  output logic   boundary
);

  phase_e phase_q;

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_T1;
    else if (tick) phase_q <= phase_e'(phase_q + 2'd1);
  end

  assign phase    = phase_q;
  assign boundary = tick && (phase_q == PH_T4);

  // R2
  phase_step_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> phase_q == phase_e'($past(phase_q) + 2'd1));

  // R2
  phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(phase_q));

endmodule

// File: rtl/fs_next_addr.sv
module fs_next_addr
  import fseq_pkg::*;
#(
  parameter int          PC_W     = 10,
  parameter int          PAGE_W   = 8,
  parameter logic [9:0]  VEC_ADDR = 10'h004
) (
  input  logic [PC_W-1:0] cur_addr,
  input  logic [PC_W-1:0] tgt_addr,
  input  logic            accept,
  input  logic            want_vec,
  input  logic            want_abs,
  input  logic            want_page,
  input  logic            want_skip,
  output logic [PC_W-1:0] next_addr,
  output logic            flush
);

  localparam logic [PC_W-1:0] VEC_PC = PC_W'(VEC_ADDR);
  localparam logic [PC_W-1:0] ONE    = PC_W'(1);

  redir_e          kind;
  logic [PC_W-1:0] page_addr;

  generate
    if (PC_W > PAGE_W) begin : g_paged
      assign page_addr = {cur_addr[PC_W-1:PAGE_W], tgt_addr[PAGE_W-1:0]};
    end else begin : g_flat
      assign page_addr = tgt_addr;
    end
  endgenerate

  always_comb begin
    kind = RD_SEQ;
    if (accept) begin
      if (want_vec)       kind = RD_VEC;
      else if (want_abs)  kind = RD_ABS;
      else if (want_page) kind = RD_PAGE;
      else if (want_skip) kind = RD_SKIP;
    end
  end

  always_comb begin
    case (kind)
      RD_VEC:  next_addr = VEC_PC;
      RD_ABS:  next_addr = tgt_addr;
      RD_PAGE: next_addr = page_addr;
      default: next_addr = cur_addr + ONE;
    endcase
  end

  assign flush = (kind != RD_SEQ);

endmodule

// File: rtl/fs_instr_reg.sv
module fs_instr_reg #(
  parameter int               INSTR_W  = 16,
  parameter logic [INSTR_W-1:0] NOP_WORD = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               flush,
  input  logic [INSTR_W-1:0] rdata,
  output logic [INSTR_W-1:0] instr,
  output logic               bubble
);

  always_ff @(posedge clk) begin
    if (rst) begin
      instr  <= NOP_WORD;
      bubble <= 1'b1;
    end else if (load) begin
      if (flush) begin
        instr  <= NOP_WORD;
        bubble <= 1'b1;
      end else begin
        instr  <= rdata;
        bubble <= 1'b0;
      end
    end
  end

  // R12
  bubble_nop_chk: assert property (@(posedge clk) disable iff (rst)
    bubble |-> instr == NOP_WORD);

endmodule

// File: rtl/fetch_sequencer.sv
module fetch_sequencer
  import fseq_pkg::*;
#(
  parameter int                PC_W     = 10,
  parameter int                PAGE_W   = 8,
  parameter int                INSTR_W  = 16,
  parameter logic [9:0]        VEC_ADDR = 10'h004,
  parameter logic [PC_W-1:0]   RST_ADDR = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               ctl_jump,
  input  logic               ctl_call,
  input  logic               ctl_skip,
  input  logic               ctl_pcl_wr,
  input  logic               ctl_vec,
  input  logic [PC_W-1:0]    tgt_addr,
  input  logic [INSTR_W-1:0] mem_rdata,
  output logic [1:0]         phase,
  output logic [PC_W-1:0]    fetch_addr,
  output logic [INSTR_W-1:0] instr,
  output logic               bubble
);

  localparam logic [INSTR_W-1:0] NOP_WORD = '0;

  phase_e          phase_w;
  logic            boundary;
  logic            flush;
  logic [PC_W-1:0] next_addr;
  logic [PC_W-1:0] pc_q;

  fs_phase_gen u_phase (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .phase    (phase_w),
    .boundary (boundary)
  );

  fs_next_addr #(
    .PC_W     (PC_W),
    .PAGE_W   (PAGE_W),
    .VEC_ADDR (VEC_ADDR)
  ) u_next (
    .cur_addr  (pc_q),
    .tgt_addr  (tgt_addr),
    .accept    (!bubble),
    .want_vec  (ctl_vec),
    .want_abs  (ctl_jump || ctl_call),
    .want_page (ctl_pcl_wr),
    .want_skip (ctl_skip),
    .next_addr (next_addr),
    .flush     (flush)
  );

  fs_instr_reg #(
    .INSTR_W  (INSTR_W),
    .NOP_WORD (NOP_WORD)
  ) u_ir (
    .clk    (clk),
    .rst    (rst),
    .load   (boundary),
    .flush  (flush),
    .rdata  (mem_rdata),
    .instr  (instr),
    .bubble (bubble)
  );

  always_ff @(posedge clk) begin
    if (rst) pc_q <= RST_ADDR;
    else if (boundary) pc_q <= next_addr;
  end

  assign phase      = phase_w;
  assign fetch_addr = pc_q;

  // R3
  pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> $stable(pc_q) && $stable(bubble) && $stable(instr));

  // R4
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    boundary && !ctl_vec && !ctl_jump && !ctl_call && !ctl_pcl_wr && !ctl_skip
      |=> pc_q == $past(pc_q) + PC_W'(1) && !bubble);

  // R6
  flush_bubble_chk: assert property (@(posedge clk) disable iff (rst)
    boundary && !bubble && (ctl_vec || ctl_jump || ctl_call || ctl_pcl_wr || ctl_skip)
      |=> bubble && instr == NOP_WORD);

  // R8
  page_keep_chk: assert property (@(posedge clk) disable iff (rst)
    boundary && !bubble && ctl_pcl_wr && !ctl_vec && !ctl_jump && !ctl_call
      |=> pc_q[PC_W-1:PAGE_W] == $past(pc_q[PC_W-1:PAGE_W]));

  // R11
  bubble_clear_chk: assert property (@(posedge clk) disable iff (rst)
    boundary && bubble |=> !bubble && instr == $past(mem_rdata));

endmodule

// File: tb/test_fetch_sequencer.sv
`timescale 1ns/1ps
module test_fetch_sequencer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        ctl_jump = 1'b0, ctl_call = 1'b0, ctl_skip = 1'b0;
  logic        ctl_pcl_wr = 1'b0, ctl_vec = 1'b0;
  logic [9:0]  tgt_addr = '0;
  logic [15:0] mem_rdata = '0;
  logic [1:0]  phase;
  logic [9:0]  fetch_addr;
  logic [15:0] instr;
  logic        bubble;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  fetch_sequencer i_fetch_sequencer (
    .clk (clk), .rst (rst), .tick (tick),
    .ctl_jump (ctl_jump), .ctl_call (ctl_call), .ctl_skip (ctl_skip),
    .ctl_pcl_wr (ctl_pcl_wr), .ctl_vec (ctl_vec),
    .tgt_addr (tgt_addr), .mem_rdata (mem_rdata),
    .phase (phase), .fetch_addr (fetch_addr), .instr (instr), .bubble (bubble)
  );

  function automatic logic [15:0] word_at(input logic [9:0] a);
    return {6'b101000, a};
  endfunction

  always_ff @(posedge clk) mem_rdata <= word_at(fetch_addr);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // strobes {vec, jump, call, pcl_wr, skip}, target, expected fetch address, expected bubble
  localparam logic [25:0] TBL [0:19] = '{
    {5'b00000, 10'h000, 10'h001, 1'b0},  // R4
    {5'b00000, 10'h000, 10'h002, 1'b0},  // R4
    {5'b01000, 10'h3FE, 10'h3FE, 1'b1},  // R6
    {5'b01000, 10'h100, 10'h3FF, 1'b0},  // R11
    {5'b00000, 10'h000, 10'h000, 1'b0},  // R5
    {5'b00001, 10'h000, 10'h001, 1'b1},  // R9
    {5'b00000, 10'h000, 10'h002, 1'b0},  // R12
    {5'b00100, 10'h2F0, 10'h2F0, 1'b1},  // R6 call
    {5'b00000, 10'h000, 10'h2F1, 1'b0},
    {5'b00010, 10'h155, 10'h255, 1'b1},  // R8
    {5'b00000, 10'h000, 10'h256, 1'b0},
    {5'b11000, 10'h123, 10'h004, 1'b1},  // R7 R10
    {5'b00000, 10'h000, 10'h005, 1'b0},
    {5'b01010, 10'h1AB, 10'h1AB, 1'b1},  // R10
    {5'b00000, 10'h000, 10'h1AC, 1'b0},
    {5'b00011, 10'h010, 10'h110, 1'b1},  // R10
    {5'b00000, 10'h000, 10'h111, 1'b0},
    {5'b00001, 10'h000, 10'h112, 1'b1},  // R9
    {5'b00001, 10'h000, 10'h113, 1'b0},  // R11
    {5'b00000, 10'h000, 10'h114, 1'b0}   // R12
  };

  task automatic drive(input logic [4:0] s, input logic [9:0] t);
    {ctl_vec, ctl_jump, ctl_call, ctl_pcl_wr, ctl_skip} = s;
    tgt_addr = t;
  endtask

  task automatic check_reset;
    chk("R1 fetch_addr", 32'(fetch_addr), 32'h000);
    chk("R1 phase", 32'(phase), 32'd0);
    chk("R1 instr", 32'(instr), 32'h0000);
    chk("R1 bubble", 32'(bubble), 32'd1);
  endtask

  initial begin
    #(200000 * 8);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [9:0] prev_addr;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_reset();
    rst = 1'b0;
    tick = 1'b1;
    prev_addr = 10'h000;

    for (int i = 0; i < 20; i++) begin
      drive(TBL[i][25:21], TBL[i][20:11]);
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk($sformatf("R4-table row %0d fetch_addr", i), 32'(fetch_addr), 32'(TBL[i][10:1]));
      chk($sformatf("R12 row %0d bubble", i), 32'(bubble), 32'(TBL[i][0]));
      chk($sformatf("R6 row %0d instr", i), 32'(instr),
          TBL[i][0] ? 32'h0 : 32'(word_at(prev_addr)));
      chk($sformatf("R2 row %0d phase", i), 32'(phase), 32'd0);
      prev_addr = TBL[i][10:1];
    end
    drive(5'b00000, 10'h000);

    // R2 R3: stalled ticks with a jump pending
    drive(5'b01000, 10'h3AA);
    tick = 1'b0;
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk("R2 phase held", 32'(phase), 32'd0);
    chk("R3 addr held", 32'(fetch_addr), 32'h114);
    tick = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R2 phase T4", 32'(phase), 32'd3);
    chk("R3 no early redirect", 32'(fetch_addr), 32'h114);
    chk("R3 bubble unchanged", 32'(bubble), 32'd0);
    tick = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R3 still held at T4", 32'(fetch_addr), 32'h114);
    tick = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tick = 1'b0;
    chk("R6 jump at boundary", 32'(fetch_addr), 32'h3AA);
    chk("R6 bubble", 32'(bubble), 32'd1);
    chk("R2 phase wrap", 32'(phase), 32'd0);
    drive(5'b00000, 10'h000);

    // R1: reset in mid-run
    tick = 1'b1;
    repeat (2) @(posedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check_reset();
    rst = 1'b0;
    finish_up();
  end

endmodule